// File: doc/BRIEF.md
# Zero-Crossing Volume Update Controller

This block sits in a digital audio path and decides when a new volume code reaches the output stage. A requested code is not applied at once. It is held as pending, and it is applied on the first sample that crosses zero. That way the gain step lands where the waveform is near zero and makes no audible click. If the signal never crosses zero, a frame-count timeout forces the change. A control input can switch the timeout off, and then the pending code waits for a crossing with no time limit.

The highest legal code, 69 (the seventieth setting), means mute. A soft-mute sequencer can take over the path. While its request is held high, it raises the code one step at a time toward mute. When the request drops, it brings the code back one step at a time to the setting the user chose. Every step obeys the same zero-crossing and timeout rule as a normal request.

Top module: `zvu_ctrl`

## Requirements
- R1: After reset, `vol_out` is 0 and both `vol_upd` and `busy` are low.
- R2: A request on `vol_req_vld` becomes pending and leaves `vol_out` unchanged. It is applied on the clock edge that accepts a sample whose sign bit differs from the previous sample of the same channel (`smp_ch` 0 or 1). At that point `vol_out` takes the code and `vol_upd` is high for one cycle.
- R3: A sample equal to zero counts as a crossing, including the first sample of a channel. Two samples of the same sign on one channel do not count. A sign change between samples of different channels does not count.
- R4: With `tmo_dis` low, a pending code with no crossing is applied at the edge that accepts the 4096th `frame_stb` pulse after the request.
- R5: A request made while another is pending replaces the pending code and restarts the frame count at zero.
- R6: While `tmo_dis` is high, a pending code is never applied by the timeout. Only a crossing applies it.
- R7: A requested code above 69 is taken as 69 (mute).
- R8: If a request and a crossing sample arrive in the same cycle, the crossing is not used. The new code stays pending until the next crossing.
- R9: While `smute_req` is high, the code rises by exactly one per step until it reaches 69. A step is issued on the `ramp_div`-th frame pulse counted while nothing is pending, and each step is applied by the R2/R4 rule.
- R10: When `smute_req` falls, the code moves one step at a time back to the restore code. The restore code is the setting in force or pending when soft mute began, replaced by any request made during the ramp or the mute. Such requests do not change `vol_out` directly.
- R11: `busy` is high exactly while a code is pending or a soft-mute ramp is in progress. It is low once mute is reached and held.
- R12: `vol_out` changes only in a cycle where `vol_upd` is high, and `vol_upd` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample word valid this cycle |
| smp_ch | input | CH_W | Channel index of the sample |
| smp_data | input | SAMPLE_W | Signed two's complement sample |
| frame_stb | input | 1 | One pulse per audio frame period |
| vol_req_vld | input | 1 | New volume request |
| vol_req | input | VOL_W | Requested volume code (0 loudest, 69 mute) |
| tmo_dis | input | 1 | Disables the frame-count timeout |
| smute_req | input | 1 | Soft-mute request, level |
| ramp_div | input | DIV_W | Frame pulses per soft-mute step |
| vol_out | output | VOL_W | Applied volume code |
| vol_upd | output | 1 | One-cycle strobe when vol_out changes |
| busy | output | 1 | Code pending or ramp in progress |

## Verification
Two functions can act in the same cycle: accepting a new request and applying the pending code on a zero crossing. The bench provokes this by driving a request and a sign-changing sample in the same cycle. It then confirms that no update strobe follows and that the newer code waits for the next crossing. A second collision is provoked at the entry to soft mute: a user request made while the ramp or the mute holds the path must not reach the output directly, and it must become the code the ramp returns to.

// File: rtl/zvu_pkg.sv
package zvu_pkg;

    // Soft-mute sequencer modes
    typedef enum logic [1:0] {
        RM_IDLE  = 2'd0,
        RM_DOWN  = 2'd1,
        RM_MUTED = 2'd2,
        RM_UP    = 2'd3
    } ramp_mode_e;

endpackage

// File: rtl/zvu_zc_detect.sv
module zvu_zc_detect #(
    parameter int SAMPLE_W = 16,
    parameter int NUM_CH   = 2,
    parameter int CH_W     = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic [CH_W-1:0]     smp_ch,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                zc
);

    typedef struct packed {
        logic [NUM_CH-1:0] sign;
        logic [NUM_CH-1:0] seen;
    } zc_st_t;

    zc_st_t s_q, s_d;

    logic              neg;
    logic              is_zero;
    logic [NUM_CH-1:0] hit;

    assign neg     = smp_data[SAMPLE_W-1];
    assign is_zero = (smp_data == '0);

    // per-channel crossing decision
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit[c] = smp_vld && (smp_ch == CH_W'(c)) &&
                        (is_zero || (s_q.seen[c] && (s_q.sign[c] != neg)));
    end

    assign zc = |hit;

    always_comb begin
        s_d = s_q;
        if (smp_vld) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (smp_ch == CH_W'(c)) begin
                    s_d.sign[c] = neg;
                    s_d.seen[c] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/zvu_apply.sv
module zvu_apply #(
    parameter int VOL_W          = 7,
    parameter int TIMEOUT_FRAMES = 4096,
    parameter int RESET_CODE     = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cancel,
    input  logic             req_vld,
    input  logic [VOL_W-1:0] req_code,
    input  logic             zc,
    input  logic             frame_stb,
    input  logic             tmo_dis,
    output logic [VOL_W-1:0] vol,
    output logic             upd,
    output logic             pend,
    output logic [VOL_W-1:0] target
);

    localparam int              TMO_CW  = (TIMEOUT_FRAMES > 1) ? $clog2(TIMEOUT_FRAMES) : 1;
    localparam logic [TMO_CW-1:0] TMO_MAX = TMO_CW'(TIMEOUT_FRAMES - 1);

    typedef struct packed {
        logic [VOL_W-1:0]  vol;
        logic              upd;
        logic              pend;
        logic [VOL_W-1:0]  target;
        logic [TMO_CW-1:0] cnt;
    } ap_st_t;

    localparam ap_st_t RESET_S = '{
        vol:    VOL_W'(RESET_CODE),
        upd:    1'b0,
        pend:   1'b0,
        target: VOL_W'(RESET_CODE),
        cnt:    '0
    };

    ap_st_t s_q, s_d;
    logic   expire;
    logic   fire;

    assign expire = frame_stb && (s_q.cnt == TMO_MAX) && !tmo_dis;
    assign fire   = s_q.pend && (zc || expire);

    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        if (cancel) begin
            s_d.pend = 1'b0;
            s_d.cnt  = '0;
        end else if (req_vld) begin
            // newest request wins, crossing in this cycle is not used
            s_d.pend   = 1'b1;
            s_d.target = req_code;
            s_d.cnt    = '0;
        end else if (fire) begin
            s_d.vol  = s_q.target;
            s_d.upd  = 1'b1;
            s_d.pend = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.pend && frame_stb && (s_q.cnt != TMO_MAX)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_S;
        else        s_q <= s_d;
    end

    assign vol    = s_q.vol;
    assign upd    = s_q.upd;
    assign pend   = s_q.pend;
    assign target = s_q.target;

endmodule

// File: rtl/zvu_ramp.sv
module zvu_ramp
    import zvu_pkg::*;
#(
    parameter int VOL_W     = 7,
    parameter int MUTE_CODE = 69,
    parameter int DIV_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smute,
    input  logic             user_vld,
    input  logic [VOL_W-1:0] user_code,
    input  logic             pend,
    input  logic [VOL_W-1:0] pend_target,
    input  logic [VOL_W-1:0] vol,
    input  logic             frame_stb,
    input  logic [DIV_W-1:0] ramp_div,
    output logic             step_vld,
    output logic [VOL_W-1:0] step_code,
    output logic             cancel,
    output logic             user_pass,
    output logic             ramping
);

    localparam logic [VOL_W-1:0] MUTE_V = VOL_W'(MUTE_CODE);

    typedef struct packed {
        ramp_mode_e       mode;
        logic [VOL_W-1:0] restore;
        logic [DIV_W-1:0] cnt;
    } rp_st_t;

    rp_st_t s_q, s_d;

    logic [DIV_W-1:0] div_max;
    logic [VOL_W-1:0] goal;
    logic             can_step;

    assign div_max = (ramp_div == '0) ? '0 : (ramp_div - 1'b1);

    always_comb begin
        s_d       = s_q;
        step_vld  = 1'b0;
        step_code = vol;
        cancel    = 1'b0;
        goal      = s_q.restore;
        can_step  = 1'b0;
        unique case (s_q.mode)
            RM_IDLE: begin
                if (smute) begin
                    s_d.mode = RM_DOWN;
                    s_d.cnt  = '0;
                    cancel   = 1'b1;
                    if (user_vld)  s_d.restore = user_code;
                    else if (pend) s_d.restore = pend_target;
                    else           s_d.restore = vol;
                end
            end
            RM_DOWN: begin
                if (user_vld) s_d.restore = user_code;
                if (!smute) begin
                    s_d.mode = RM_UP;
                    s_d.cnt  = '0;
                end else if (!pend && (vol == MUTE_V)) begin
                    s_d.mode = RM_MUTED;
                end else begin
                    goal     = MUTE_V;
                    can_step = 1'b1;
                end
            end
            RM_MUTED: begin
                if (user_vld) s_d.restore = user_code;
                if (!smute) begin
                    s_d.mode = RM_UP;
                    s_d.cnt  = '0;
                end
            end
            RM_UP: begin
                if (user_vld) s_d.restore = user_code;
                if (smute) begin
                    s_d.mode = RM_DOWN;
                    s_d.cnt  = '0;
                end else if (!pend && !user_vld && (vol == s_q.restore)) begin
                    s_d.mode = RM_IDLE;
                end else begin
                    goal     = s_q.restore;
                    can_step = 1'b1;
                end
            end
            default: s_d.mode = RM_IDLE;
        endcase

        // frame-paced stepping, paused while a step waits for its crossing
        if (can_step && !pend && (vol != goal) && frame_stb) begin
            if (s_q.cnt == div_max) begin
                step_vld  = 1'b1;
                step_code = (vol < goal) ? (vol + 1'b1) : (vol - 1'b1);
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode    <= RM_IDLE;
            s_q.restore <= '0;
            s_q.cnt     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign user_pass = (s_q.mode == RM_IDLE) && !smute;
    assign ramping   = (s_q.mode == RM_DOWN) || (s_q.mode == RM_UP);

endmodule

// File: rtl/zvu_ctrl.sv
module zvu_ctrl #(
    parameter int SAMPLE_W       = 16,
    parameter int NUM_CH         = 2,
    parameter int VOL_W          = 7,
    parameter int MUTE_CODE      = 69,
    parameter int TIMEOUT_FRAMES = 4096,
    parameter int DIV_W          = 4,
    parameter int RESET_CODE     = 0,
    localparam int CH_W          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic [CH_W-1:0]     smp_ch,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                frame_stb,
    input  logic                vol_req_vld,
    input  logic [VOL_W-1:0]    vol_req,
    input  logic                tmo_dis,
    input  logic                smute_req,
    input  logic [DIV_W-1:0]    ramp_div,
    output logic [VOL_W-1:0]    vol_out,
    output logic                vol_upd,
    output logic                busy
);

    localparam logic [VOL_W-1:0] MUTE_V = VOL_W'(MUTE_CODE);

    logic             zc;
    logic [VOL_W-1:0] user_code;
    logic             step_vld;
    logic [VOL_W-1:0] step_code;
    logic             cancel;
    logic             user_pass;
    logic             ramping;
    logic             pend;
    logic [VOL_W-1:0] target;
    logic             ap_req_vld;
    logic [VOL_W-1:0] ap_req_code;

    assign user_code   = (vol_req > MUTE_V) ? MUTE_V : vol_req;
    assign ap_req_vld  = user_pass ? vol_req_vld : step_vld;
    assign ap_req_code = user_pass ? user_code   : step_code;

    zvu_zc_detect #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_CH   (NUM_CH),
        .CH_W     (CH_W)
    ) u_zc (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp_ch   (smp_ch),
        .smp_data (smp_data),
        .zc       (zc)
    );

    zvu_apply #(
        .VOL_W          (VOL_W),
        .TIMEOUT_FRAMES (TIMEOUT_FRAMES),
        .RESET_CODE     (RESET_CODE)
    ) u_apply (
        .clk       (clk),
        .rst_n     (rst_n),
        .cancel    (cancel),
        .req_vld   (ap_req_vld),
        .req_code  (ap_req_code),
        .zc        (zc),
        .frame_stb (frame_stb),
        .tmo_dis   (tmo_dis),
        .vol       (vol_out),
        .upd       (vol_upd),
        .pend      (pend),
        .target    (target)
    );

    zvu_ramp #(
        .VOL_W     (VOL_W),
        .MUTE_CODE (MUTE_CODE),
        .DIV_W     (DIV_W)
    ) u_ramp (
        .clk         (clk),
        .rst_n       (rst_n),
        .smute       (smute_req),
        .user_vld    (vol_req_vld),
        .user_code   (user_code),
        .pend        (pend),
        .pend_target (target),
        .vol         (vol_out),
        .frame_stb   (frame_stb),
        .ramp_div    (ramp_div),
        .step_vld    (step_vld),
        .step_code   (step_code),
        .cancel      (cancel),
        .user_pass   (user_pass),
        .ramping     (ramping)
    );

    assign busy = pend || ramping;

endmodule

// File: rtl/zvu_ctrl_chk.sv
module zvu_ctrl_chk #(
    parameter int VOL_W     = 7,
    parameter int MUTE_CODE = 69
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic             tmo_dis,
    input logic [VOL_W-1:0] vol_out,
    input logic             vol_upd,
    input logic             busy
);

    // R12
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vol_upd |=> !vol_upd);

    // R12
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vol_upd |-> $stable(vol_out));

    // R7
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vol_out <= VOL_W'(MUTE_CODE));

    // R11
    busy_before_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vol_upd |-> $past(busy));

    // R6
    no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vol_upd && $past(tmo_dis)) |-> $past(smp_vld));

endmodule

bind zvu_ctrl zvu_ctrl_chk #(
    .VOL_W     (VOL_W),
    .MUTE_CODE (MUTE_CODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .tmo_dis (tmo_dis),
    .vol_out (vol_out),
    .vol_upd (vol_upd),
    .busy    (busy)
);

// File: tb/zvu_ctrl_tb.sv
module zvu_ctrl_tb;

    localparam int SAMPLE_W = 16;
    localparam int VOL_W    = 7;
    localparam int DIV_W    = 4;
    localparam int MUTE     = 69;
    localparam int TMO      = 4096;

    logic                clk;
    logic                rst_n;
    logic                smp_vld;
    logic [0:0]          smp_ch;
    logic [SAMPLE_W-1:0] smp_data;
    logic                frame_stb;
    logic                vol_req_vld;
    logic [VOL_W-1:0]    vol_req;
    logic                tmo_dis;
    logic                smute_req;
    logic [DIV_W-1:0]    ramp_div;
    logic [VOL_W-1:0]    vol_out;
    logic                vol_upd;
    logic                busy;

    zvu_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .smp_ch      (smp_ch),
        .smp_data    (smp_data),
        .frame_stb   (frame_stb),
        .vol_req_vld (vol_req_vld),
        .vol_req     (vol_req),
        .tmo_dis     (tmo_dis),
        .smute_req   (smute_req),
        .ramp_div    (ramp_div),
        .vol_out     (vol_out),
        .vol_upd     (vol_upd),
        .busy        (busy)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    int    exp_code[$];
    string exp_tag[$];
    bit    ch0_neg = 1'b0;
    bit    ended   = 1'b0;

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_upd(int code, string tag);
        exp_code.push_back(code);
        exp_tag.push_back(tag);
    endtask

    task automatic sample(int ch, int val);
        smp_vld  = 1'b1;
        smp_ch   = ch[0:0];
        smp_data = SAMPLE_W'(val);
        cyc();
        smp_vld  = 1'b0;
    endtask

    task automatic cross0();
        ch0_neg = !ch0_neg;
        sample(0, ch0_neg ? -100 : 100);
    endtask

    task automatic same0();
        sample(0, ch0_neg ? -60 : 60);
    endtask

    task automatic frames(int n);
        for (int i = 0; i < n; i++) begin
            frame_stb = 1'b1;
            cyc();
        end
        frame_stb = 1'b0;
    endtask

    task automatic request(int code);
        vol_req_vld = 1'b1;
        vol_req     = VOL_W'(code);
        cyc();
        vol_req_vld = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // scoreboard monitor: every update strobe is matched against the queue
    always @(negedge clk) begin
        if (rst_n && vol_upd) begin
            if (exp_code.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R12 unexpected update: got %0d expected none", vol_out);
            end else begin
                int    c;
                string t;
                c = exp_code.pop_front();
                t = exp_tag.pop_front();
                chk(t, int'(vol_out), c);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n       = 1'b0;
        smp_vld     = 1'b0;
        smp_ch      = '0;
        smp_data    = '0;
        frame_stb   = 1'b0;
        vol_req_vld = 1'b0;
        vol_req     = '0;
        tmo_dis     = 1'b0;
        smute_req   = 1'b0;
        ramp_div    = DIV_W'(2);
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk("R1 vol_out", int'(vol_out), 0);
        chk("R1 vol_upd", int'(vol_upd), 0);
        chk("R1 busy", int'(busy), 0);

        same0();                       // prime channel 0, positive
        // R2 crossing applies the pending code
        request(10);
        chk("R11 busy while pending", int'(busy), 1);
        same0();
        same0();
        chk("R2 held without crossing", int'(vol_out), 0);
        expect_upd(10, "R2 sign change");
        cross0();
        chk("R11 busy low after apply", int'(busy), 0);

        // R3 exact zero on a fresh channel
        request(20);
        expect_upd(20, "R3 zero sample");
        sample(1, 0);
        sample(1, 40);                 // channel 1 positive, channel 0 negative
        request(30);
        sample(1, 41);
        same0();
        chk("R3 cross-channel ignored", int'(vol_out), 20);
        sample(1, 42);
        chk("R3 cross-channel ignored again", int'(vol_out), 20);
        expect_upd(30, "R3 same-channel crossing");
        cross0();

        // R5 replacement restarts the count, R4 timeout on the 4096th frame
        request(40);
        frames(100);
        request(41);
        frames(TMO - 1);
        chk("R5 count restarted", int'(vol_out), 30);
        chk("R4 still pending", int'(busy), 1);
        expect_upd(41, "R4 timeout apply");
        frames(1);

        // R6 timeout disabled
        tmo_dis = 1'b1;
        request(50);
        frames(TMO + 500);
        chk("R6 no timeout apply", int'(vol_out), 41);
        chk("R6 still busy", int'(busy), 1);
        expect_upd(50, "R6 crossing apply");
        cross0();
        tmo_dis = 1'b0;

        // R7 clamp
        request(100);
        expect_upd(MUTE, "R7 clamp to mute");
        cross0();
        request(5);
        expect_upd(5, "R2 return from mute code");
        cross0();

        // R8 request and crossing in the same cycle
        vol_req_vld = 1'b1;
        vol_req     = VOL_W'(7);
        ch0_neg     = !ch0_neg;
        smp_vld     = 1'b1;
        smp_ch      = '0;
        smp_data    = SAMPLE_W'(ch0_neg ? -100 : 100);
        cyc();
        vol_req_vld = 1'b0;
        smp_vld     = 1'b0;
        chk("R8 crossing not used", int'(vol_out), 5);
        chk("R8 pending", int'(busy), 1);
        expect_upd(7, "R8 next crossing");
        cross0();

        // R9 soft-mute ramp down
        smute_req = 1'b1;
        cyc();
        chk("R11 busy during ramp", int'(busy), 1);
        frames(1);
        cross0();
        chk("R9 no step before ramp_div frames", int'(vol_out), 7);
        frames(1);
        expect_upd(8, "R9 first step");
        cross0();
        for (int v = 9; v <= MUTE; v++) begin
            expect_upd(v, "R9 ramp step");
            frames(2);
            cross0();
        end
        repeat (3) cyc();
        chk("R9 reached mute", int'(vol_out), MUTE);
        chk("R11 busy low when muted", int'(busy), 0);

        // R10 request while muted only changes the restore code
        request(12);
        frames(6);
        cross0();
        cross0();
        chk("R10 muted output held", int'(vol_out), MUTE);

        smute_req = 1'b0;
        cyc();
        for (int v = MUTE - 1; v >= 12; v--) begin
            expect_upd(v, "R10 ramp back");
            frames(2);
            cross0();
        end
        repeat (3) cyc();
        chk("R10 restored code", int'(vol_out), 12);
        chk("R11 busy low after restore", int'(busy), 0);

        request(3);
        expect_upd(3, "R2 normal path after restore");
        cross0();
        repeat (3) cyc();
        chk("R12 no missing updates", exp_code.size(), 0);

        finish_run();
    end

endmodule